// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a memory-mapped general-purpose I/O controller. It serves up to six banks of up to 32 pins over a simple register bus with a byte address, a write strobe, write data and combinational read data. For each pin it provides level readback, direction control and an output latch. Software updates the latch through separate write-one-to-set and write-one-to-clear registers, so no read-modify-write is needed. Each pin also has its own rising-edge and falling-edge detect enables, a mask, and a sticky status bit.

Pad inputs pass through a two-flop synchronizer. An edge is detected by comparing the synchronized level with its value one cycle earlier. An edge that is enabled and unmasked latches the status bit, and one combined interrupt request stays high while any status bit whose mask bit is set is pending. Pads are modelled as input, output and output-enable vectors. A parameter mask marks pins whose direction bit has the reversed meaning. The last bank may be partial. Its missing pins read as zero and ignore writes.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: After reset the direction register of every bank reads back the inverted-pin mask for that bank, so every pad_oe bit is 0. Output latches, rising and falling enables and status read 0. Every mask register reads all ones over its implemented pins. irq and pad_out are 0.
- R2: Register offsets inside a group are level 0x00, direction 0x0C, set 0x18, clear 0x24, rising enable 0x30, falling enable 0x3C, status 0x48 and mask 0x9C. Bank n adds 4*n for banks 0 to 2. Banks 3 to 5 use the same layout starting at 0x100. A bank's write reaches only that bank's register.
- R3: In a write to the set register, each 1 bit drives that pin's output latch high. In a write to the clear register, each 1 bit drives it low. Zero bits leave the latch unchanged. Both registers read back the latch, and pad_out follows one clock after the write.
- R4: pad_oe for a pin equals its direction bit, where 1 means output. On pins whose bit in INV_MASK is set, pad_oe is the inverse of the direction bit.
- R5: The level register returns the synchronized pad_in value whatever the pin's direction. A pad change is visible after exactly two rising clock edges. Writes to the level register have no effect.
- R6: With only the rising enable set, only 0-to-1 transitions set the status bit. With only the falling enable set, only 1-to-0 transitions set it. With both set, either transition sets it. The status bit appears three clock edges after the pad change.
- R7: Status bits are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R8: A pin whose mask bit is 0 never newly sets its status bit. A pending status bit whose mask bit is cleared no longer drives irq, but it still reads back as set.
- R9: When a write-one-to-clear and a new edge reach the same status bit in the same cycle, the bit stays set.
- R10: Pins above NUM_PINS in the last bank read as 0 in every register, and writes to them have no effect.
- R11: irq is high exactly while some bank has a status bit set whose mask bit is also set.
- R12: Reads of unaligned addresses, of offsets outside the register map, or of banks that do not exist return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | NUM_PINS | Asynchronous pad input levels |
| pad_out | output | NUM_PINS | Output latch driven to the pads |
| pad_oe | output | NUM_PINS | Pad output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
A software clear of the status register and a new edge on the same pin can land on the same clock edge. The bench provokes this by raising a pad and counting the two synchronizer edges. It then drives the write-one-to-clear so that the write commits on the edge where the detected transition is latched. The status bit must read back as set afterwards. A control run with the same clear and no coincident edge must read it as clear, which shows that the clear itself works and that edge priority is what kept the bit.

// File: rtl/gpio_banked_pkg.sv
package gpio_banked_pkg;

  typedef enum logic [2:0] {
    RK_LEVEL = 3'd0,
    RK_DIR   = 3'd1,
    RK_SET   = 3'd2,
    RK_CLR   = 3'd3,
    RK_RISE  = 3'd4,
    RK_FALL  = 3'd5,
    RK_STAT  = 3'd6,
    RK_MASK  = 3'd7
  } reg_kind_e;

  typedef struct packed {
    logic      hit;
    reg_kind_e kind;
    logic [2:0] bank;
  } reg_sel_t;

  // Byte address -> register kind and bank. Each group holds three banks
  // at a 4-byte stride; group 1 starts at 0x100.
  function automatic reg_sel_t decode_addr(input logic [11:0] a, input int nbank);
    reg_sel_t s;
    int word;
    int sub;
    int bnk;
    s = '{hit: 1'b0, kind: RK_LEVEL, bank: 3'd0};
    word = int'(a[7:2]);
    sub = 0;
    if (a[1:0] != 2'b00 || a[11:9] != 3'b000) return s;
    if (word < 21) begin
      s.kind = reg_kind_e'(3'(word / 3));
      sub = word % 3;
    end else if (word >= 39 && word <= 41) begin
      s.kind = RK_MASK;
      sub = word - 39;
    end else begin
      return s;
    end
    bnk = (a[8] ? 3 : 0) + sub;
    s.bank = 3'(bnk);
    s.hit = (bnk < nbank);
    return s;
  endfunction

  // Number of implemented pins in bank b.
  function automatic int bank_width(input int pins, input int b);
    int rest;
    rest = pins - b * 32;
    return (rest >= 32) ? 32 : rest;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] lvl,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      lvl    <= '0;
      prev   <= '0;
    end else begin
      meta_q <= raw;
      lvl    <= meta_q;
      prev   <= lvl;
    end
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_banked_pkg::*;
#(
  parameter int           W   = 32,
  parameter logic [W-1:0] INV = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  reg_kind_e    kind,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] prev,
  output logic [31:0]  rdata,
  output logic [W-1:0] out_q,
  output logic [W-1:0] oe,
  output logic         edge_seen,
  output logic         irq_req
);
  logic [W-1:0] dir_q, rise_q, fall_q, stat_q, mask_q;
  logic [W-1:0] rise_hit, fall_hit, edge_hit, pending;
  logic we_dir, we_set, we_clr, we_rise, we_fall, we_stat, we_mask;

  assign we_dir  = wr_en && (kind == RK_DIR);
  assign we_set  = wr_en && (kind == RK_SET);
  assign we_clr  = wr_en && (kind == RK_CLR);
  assign we_rise = wr_en && (kind == RK_RISE);
  assign we_fall = wr_en && (kind == RK_FALL);
  assign we_stat = wr_en && (kind == RK_STAT);
  assign we_mask = wr_en && (kind == RK_MASK);

  assign rise_hit  = lvl & ~prev & rise_q & mask_q;
  assign fall_hit  = ~lvl & prev & fall_q & mask_q;
  assign edge_hit  = rise_hit | fall_hit;
  assign edge_seen = |edge_hit;
  assign pending   = stat_q & mask_q;
  assign irq_req   = |pending;
  assign oe        = dir_q ^ INV;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= INV;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      stat_q <= '0;
      mask_q <= '1;
    end else begin
      if (we_dir)  dir_q  <= wdata;
      if (we_set)  out_q  <= out_q | wdata;
      if (we_clr)  out_q  <= out_q & ~wdata;
      if (we_rise) rise_q <= wdata;
      if (we_fall) fall_q <= wdata;
      if (we_mask) mask_q <= wdata;
      stat_q <= (stat_q & ~(we_stat ? wdata : '0)) | edge_hit;
    end
  end

  always_comb begin
    unique case (kind)
      RK_LEVEL:       rdata = 32'(lvl);
      RK_DIR:         rdata = 32'(dir_q);
      RK_SET, RK_CLR: rdata = 32'(out_q);
      RK_RISE:        rdata = 32'(rise_q);
      RK_FALL:        rdata = 32'(fall_q);
      RK_STAT:        rdata = 32'(stat_q);
      RK_MASK:        rdata = 32'(mask_q);
      default:        rdata = '0;
    endcase
  end

  p_set_drives_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we_set |=> ((out_q & $past(wdata)) == $past(wdata)));
  p_clr_drives_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we_clr |=> ((out_q & $past(wdata)) == '0));
  p_w1c_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    we_stat |=> ((stat_q & $past(wdata & ~edge_hit)) == '0));
  p_edge_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> ((stat_q & $past(edge_hit)) == $past(edge_hit)));
  p_masked_no_new_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(mask_q)) == '0));
endmodule

// File: rtl/gpio_banked_ctrl.sv
module gpio_banked_ctrl
  import gpio_banked_pkg::*;
#(
  parameter int                  NUM_PINS = 112,
  parameter int                  ADDR_W   = 12,
  parameter logic [NUM_PINS-1:0] INV_MASK = 'h30
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic                irq
);
  localparam int NBANK = (NUM_PINS + 31) / 32;

  reg_sel_t              sel;
  logic [NUM_PINS-1:0]   lvl, prev;
  logic [31:0]           bank_rd [NBANK];
  logic [NBANK-1:0]      bank_irq, bank_edge;
  logic                  mask_wr;
  logic                  any_edge;

  assign sel      = decode_addr(12'(bus_addr), NBANK);
  assign mask_wr  = bus_we && sel.hit && (sel.kind == RK_MASK);
  assign any_edge = |bank_edge;

  gpio_in_sync #(.W(NUM_PINS)) i_sync (
    .clk(clk), .rst_n(rst_n), .raw(pad_in), .lvl(lvl), .prev(prev)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int BW = bank_width(NUM_PINS, b);
    localparam int LO = b * 32;
    logic bank_wr;
    assign bank_wr = bus_we && sel.hit && (int'(sel.bank) == b);

    gpio_bank_regs #(.W(BW), .INV(INV_MASK[LO +: BW])) i_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bank_wr),
      .kind     (sel.kind),
      .wdata    (bus_wdata[BW-1:0]),
      .lvl      (lvl[LO +: BW]),
      .prev     (prev[LO +: BW]),
      .rdata    (bank_rd[b]),
      .out_q    (pad_out[LO +: BW]),
      .oe       (pad_oe[LO +: BW]),
      .edge_seen(bank_edge[b]),
      .irq_req  (bank_irq[b])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NBANK; b++)
      if (sel.hit && int'(sel.bank) == b) bus_rdata = bank_rd[b];
  end

  assign irq = |bank_irq;

  p_irq_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(any_edge) || $past(mask_wr)));
endmodule

// File: tb/test_gpio_banked_ctrl.sv
module test_gpio_banked_ctrl;
  localparam int NP = 112;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;
  logic          irq;

  int  n_run = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  gpio_banked_ctrl i_gpio_banked_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  // {we, addr[11:0], wdata[31:0], expected read[31:0]}
  localparam int NV = 26;
  localparam logic [76:0] VEC [NV] = '{
    {1'b0, 12'h00C, 32'h0, 32'h0000_0030},  // R1 dir resets to inverted mask
    {1'b0, 12'h09C, 32'h0, 32'hFFFF_FFFF},  // R1 mask resets to ones
    {1'b0, 12'h19C, 32'h0, 32'h0000_FFFF},  // R10 partial bank mask
    {1'b0, 12'h048, 32'h0, 32'h0000_0000},  // R1 status clear
    {1'b1, 12'h018, 32'h0000_00F1, 32'h0},
    {1'b0, 12'h018, 32'h0, 32'h0000_00F1},  // R3 set
    {1'b1, 12'h024, 32'h0000_0011, 32'h0},
    {1'b0, 12'h024, 32'h0, 32'h0000_00E0},  // R3 clear
    {1'b1, 12'h01C, 32'hA5A5_0000, 32'h0},
    {1'b0, 12'h028, 32'h0, 32'hA5A5_0000},  // R2 bank1 stride
    {1'b0, 12'h018, 32'h0, 32'h0000_00E0},  // R2 bank0 untouched
    {1'b1, 12'h118, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 12'h124, 32'h0, 32'h0000_FFFF},  // R10 bank3 upper bits
    {1'b1, 12'h014, 32'h1234_5678, 32'h0},
    {1'b0, 12'h014, 32'h0, 32'h1234_5678},  // R2 bank2 dir
    {1'b0, 12'h00C, 32'h0, 32'h0000_0030},  // R2 bank0 dir untouched
    {1'b1, 12'h034, 32'h0000_00FF, 32'h0},
    {1'b0, 12'h034, 32'h0, 32'h0000_00FF},  // R2 bank1 rise enable
    {1'b0, 12'h030, 32'h0, 32'h0000_0000},  // R2 bank0 rise enable
    {1'b0, 12'h054, 32'h0, 32'h0000_0000},  // R12 unmapped offset
    {1'b0, 12'h114, 32'h0, 32'h0000_0000},  // R12 missing bank 5
    {1'b0, 12'h00E, 32'h0, 32'h0000_0000},  // R12 unaligned
    {1'b0, 12'h200, 32'h0, 32'h0000_0000},  // R12 out of range
    {1'b0, 12'h10C, 32'h0, 32'h0000_0000},  // R2 bank3 dir
    {1'b1, 12'h000, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 12'h000, 32'h0, 32'h0000_0000}   // R5 level ignores writes
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1 check(bus_rdata, exp, tag);
  endtask

  task automatic pin(input int idx, input logic v);
    @(negedge clk);
    pad_in[idx] = v;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check({30'd0, irq, pad_oe[0]}, 32'd0, "R1 irq/oe at reset");
    check(pad_out[31:0], 32'd0, "R1 pad_out at reset");
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][76]) wr(VEC[i][75:64], VEC[i][63:32]);
      else rd(VEC[i][75:64], VEC[i][31:0], $sformatf("table row %0d", i));
    end

    #1 check(32'(pad_out[7:0]), 32'hE0, "R3 pad_out bank0");
    check(pad_out[63:32], 32'hA5A5_0000, "R3 pad_out bank1");
    check(32'(pad_out[111:96]), 32'h0000_FFFF, "R10 pad_out bank3");
    check(pad_oe[31:0], 32'h0, "R4 inverted pins input");
    check(pad_oe[95:64], 32'h1234_5678, "R4 oe bank2");
    wr(12'h00C, 32'h0000_000F);
    #1 check(pad_oe[31:0], 32'h0000_003F, "R4 inverted pins flip");

    // R5: level on an output pin, two-edge latency
    @(negedge clk);
    bus_addr = 12'h000; pad_in[1] = 1'b1; pad_in[100] = 1'b1;
    @(posedge clk); #1 check(bus_rdata, 32'h0, "R5 after one edge");
    @(posedge clk); #1 check(bus_rdata, 32'h2, "R5 after two edges");
    rd(12'h100, 32'h0000_0010, "R5 bank3 level");

    // R6: edge enables, bit8 rise, bit9 fall, bit10 both
    wr(12'h030, 32'h0000_0500);
    wr(12'h03C, 32'h0000_0600);
    @(negedge clk); bus_addr = 12'h048; pad_in[8] = 1'b1;
    repeat (2) @(posedge clk); #1 check(bus_rdata, 32'h0, "R6 before third edge");
    @(posedge clk); #1 check(bus_rdata, 32'h100, "R6 rise detected");
    check(32'(irq), 32'd1, "R11 irq on pending");
    wr(12'h048, 32'hFFFF_FFFF);
    rd(12'h048, 32'h0, "R7 w1c all");
    #1 check(32'(irq), 32'd0, "R11 irq cleared");
    pin(8, 1'b0);  rd(12'h048, 32'h0,   "R6 rise-only ignores fall");
    pin(9, 1'b1);  rd(12'h048, 32'h0,   "R6 fall-only ignores rise");
    pin(9, 1'b0);  rd(12'h048, 32'h200, "R6 fall detected");
    wr(12'h048, 32'h200);
    pin(10, 1'b1); rd(12'h048, 32'h400, "R6 both rise");
    wr(12'h048, 32'h400);
    pin(10, 1'b0); rd(12'h048, 32'h400, "R6 both fall");
    wr(12'h048, 32'h400);

    // R7: zero bits do not clear
    pin(8, 1'b1);
    wr(12'h048, 32'h0000_0200);
    rd(12'h048, 32'h100, "R7 zero bits keep status");

    // R8 / R11: masking
    wr(12'h09C, 32'hFFFF_FEFF);
    rd(12'h048, 32'h100, "R8 masked status still reads");
    #1 check(32'(irq), 32'd0, "R8 masked status drops irq");
    wr(12'h09C, 32'hFFFF_FFFF);
    #1 check(32'(irq), 32'd1, "R11 unmask restores irq");
    wr(12'h048, 32'hFFFF_FFFF);
    wr(12'h09C, 32'hFFFF_FBFF);
    pin(10, 1'b1);
    rd(12'h048, 32'h0, "R8 masked pin sets nothing");
    #1 check(32'(irq), 32'd0, "R8 irq stays low");
    wr(12'h09C, 32'hFFFF_FFFF);

    // R9: clear and new edge on the same edge
    pin(8, 1'b0);
    @(negedge clk); pad_in[8] = 1'b1;
    repeat (2) @(posedge clk);
    wr(12'h048, 32'h0000_0100);
    rd(12'h048, 32'h100, "R9 edge beats clear");
    wr(12'h048, 32'h0000_0100);
    rd(12'h048, 32'h0, "R9 control clear");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule